// File: doc/BRIEF.md
# Incremental Encoder Up/Down Counter Channel

This block is a single channel of a 24-bit up/down counter for incremental shaft encoders. It samples the two phase inputs and the index input on the system clock. A decoder turns phase changes into count-up and count-down pulses, with a plain clock-and-direction mode and three quadrature resolutions. A counter core applies one of four counting disciplines. Two toggle flags, one flipped on each wrap in each direction, extend the range by one bit: their XOR is count bit 24.

A host reaches the channel through a byte-wide synchronous strobe port with two addresses. The control address takes configuration and commands, with the target chosen by the top three bits of the written byte. Reading the control address returns status. The data address moves the 24-bit preset register (on writes) and the output latch (on reads) one byte at a time, least significant byte first, through a shared byte pointer.

The decoder is a four-state phase machine. Its states are PH_LL, PH_HL, PH_HH and PH_LH, named by the sampled levels of A and B. Each cycle it moves to the state matching the newly sampled pair. Forward transitions run PH_LL→PH_HL→PH_HH→PH_LH→PH_LL. Reverse transitions run the opposite way. A jump to the diagonal state, where both inputs change at once, is an illegal transition. The counter core has two run states. RUN_ACTIVE is left for RUN_HALTED on a wrap in non-recycle mode. RUN_HALTED returns to RUN_ACTIVE on a preset load or a counter clear.

Top module: `qenc_channel`

## Requirements
- R1: After reset the status byte reads 0x00, the byte pointer is at byte 0, the output latch and preset are 0, and all modes are 0 (binary normal count, non-quadrature, inputs disabled, index loads preset, index asynchronous and negative).
- R2: A control write decodes bits 7:5 as the target: 000 command, 001 count-mode register, 010 input/output register, 011 index register; the low five bits are the payload. A write with any other target code changes no state.
- R3: Data writes store the preset and data reads return the latch, least significant byte first. Each data access advances the pointer, which returns to byte 0 after the third byte. Command payload bit 0 returns the pointer to byte 0.
- R4: In a command, bit 3 loads the preset into the counter, and bit 4 copies into the latch the counter value from before this write. Field 2:1 = 01 clears the counter, 10 clears both toggle flags, and 11 clears the noise flag. A preset load overrides a counter clear in the same write.
- R5: A control read returns the borrow toggle in bit 0, the carry toggle in bit 1, the noise flag in bit 4, and the last count direction in bit 5 (1 = up). The other bits are 0.
- R6: In non-quadrature mode, with input-register bit 0 set, each rising edge of A counts one step: up when B is high, down when B is low. With bit 0 clear, A and B have no effect on the count.
- R7: Count-mode bits 4:3 select the input mode: 0 non-quadrature, 1 x1, 2 x2, 3 x4. With A leading B the count goes up. x4 counts every legal phase change. x2 counts only the changes of A. x1 counts only the A changes that happen while B is low.
- R8: In a quadrature mode with the inputs enabled, a sample in which A and B both change sets the noise flag and produces no count.
- R9: In normal mode (count-mode bits 2:1 = 0), the count wraps from 0xFFFFFF to 0 and toggles the carry flag, and wraps from 0 to 0xFFFFFF and toggles the borrow flag. Count bit 24 is borrow XOR carry.
- R10: In range-limit mode (bits 2:1 = 1), an up step while the count equals the preset, or a down step while the count is 0, leaves the count unchanged.
- R11: In non-recycle mode (bits 2:1 = 2), a wrap behaves as in normal mode and then freezes the count until a preset load or a counter clear.
- R12: In modulo-n mode (bits 2:1 = 3), an up step from the preset value goes to 0 and toggles carry, and a down step from 0 goes to the preset value and toggles borrow.
- R13: An index event occurs on the edge into the active level: rising when index-register bit 1 is 1, falling when it is 0. The event loads the preset when input-register bit 1 is 0, and does nothing when it is 1. With index-register bit 0 set in a quadrature mode, the active level must coincide with A and B both low. In non-quadrature mode that bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_stb | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read for the current strobe |
| host_ctl | input | 1 | 1 = control/status address, 0 = data address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte: status, or latch byte at the pointer |
| enc_a | input | 1 | Encoder phase A, or the count clock in non-quadrature mode |
| enc_b | input | 1 | Encoder phase B, or the direction in non-quadrature mode |
| enc_idx | input | 1 | Encoder index input |

## Verification
The bench drives the count through both wrap points. It checks the status byte exactly each time: a design that toggled the wrong flag, or toggled on an ordinary step, would report a wrong bit 24. Random walks in every quadrature resolution and in modulo-n mode are compared with a bench model. A decoder that counted the wrong edges in x1 or x2, or confused direction, would drift from that model. Directed cases cover:
- the pointer wrap after the third byte, and a mid-transfer pointer reset;
- a combined load-and-latch command, which must latch the old count;
- the range limits and the non-recycle freeze;
- a diagonal phase jump, which must flag noise and not count;
- an index event whose synchronous qualification comes from the phase inputs, arriving in the same cycle as a count step, where the load must win.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Control-port target codes (bits 7:5 of a control write)
    localparam logic [2:0] TGT_CMD  = 3'b000;
    localparam logic [2:0] TGT_MODE = 3'b001;
    localparam logic [2:0] TGT_IOC  = 3'b010;
    localparam logic [2:0] TGT_IDX  = 3'b011;

    typedef enum logic [1:0] {
        CM_NORMAL  = 2'd0,
        CM_RANGE   = 2'd1,
        CM_ONESHOT = 2'd2,
        CM_MODULO  = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        IM_PLAIN = 2'd0,
        IM_X1    = 2'd1,
        IM_X2    = 2'd2,
        IM_X4    = 2'd3
    } in_mode_e;

    // Phase states named by sampled {A,B}
    typedef enum logic [1:0] {
        PH_LL = 2'b00,
        PH_LH = 2'b01,
        PH_HL = 2'b10,
        PH_HH = 2'b11
    } phase_e;

    typedef enum logic {
        RUN_ACTIVE = 1'b0,
        RUN_HALTED = 1'b1
    } run_e;

endpackage

// File: rtl/qenc_host.sv
module qenc_host
    import qenc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             wr,
    input  logic             sel_ctl,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             bt,
    input  logic             ct,
    input  logic             err,
    input  logic             dir,
    output logic [CNT_W-1:0] preset,
    output cnt_mode_e        cmode,
    output in_mode_e         imode,
    output logic             ab_en,
    output logic             idx_load_n,
    output logic             idx_sync,
    output logic             idx_pol,
    output logic             cmd_load,
    output logic             cmd_clr_cnt,
    output logic             cmd_clr_flags,
    output logic             cmd_clr_err
);
    localparam int NBYTES = CNT_W / 8;
    localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NBYTES - 1);

    logic [2:0] tgt;
    logic [4:0] pay;
    logic       ctl_wr, data_wr, data_rd, cmd_hit;
    logic [PTR_W-1:0] ptr_q;
    logic [7:0] pre_b [NBYTES];
    logic [CNT_W-1:0] latch_q;

    assign tgt     = wdata[7:5];
    assign pay     = wdata[4:0];
    assign ctl_wr  = stb & wr & sel_ctl;
    assign data_wr = stb & wr & ~sel_ctl;
    assign data_rd = stb & ~wr & ~sel_ctl;
    assign cmd_hit = ctl_wr && (tgt == TGT_CMD);

    assign cmd_load      = cmd_hit & pay[3];
    assign cmd_clr_cnt   = cmd_hit && (pay[2:1] == 2'b01);
    assign cmd_clr_flags = cmd_hit && (pay[2:1] == 2'b10);
    assign cmd_clr_err   = cmd_hit && (pay[2:1] == 2'b11);

    // Byte pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ptr_q <= '0;
        else if (cmd_hit && pay[0]) ptr_q <= '0;
        else if (data_wr || data_rd)
            ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
    end

    // Preset bytes
    for (genvar g = 0; g < NBYTES; g++) begin : g_pre
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   pre_b[g] <= '0;
            else if (data_wr && (ptr_q == PTR_W'(g)))     pre_b[g] <= wdata;
        end
        assign preset[8*g +: 8] = pre_b[g];
    end

    // Output latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 latch_q <= '0;
        else if (cmd_hit && pay[4]) latch_q <= cnt;
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmode      <= CM_NORMAL;
            imode      <= IM_PLAIN;
            ab_en      <= 1'b0;
            idx_load_n <= 1'b0;
            idx_sync   <= 1'b0;
            idx_pol    <= 1'b0;
        end else if (ctl_wr) begin
            unique case (tgt)
                TGT_MODE: begin
                    cmode <= cnt_mode_e'(pay[2:1]);
                    imode <= in_mode_e'(pay[4:3]);
                end
                TGT_IOC: begin
                    ab_en      <= pay[0];
                    idx_load_n <= pay[1];
                end
                TGT_IDX: begin
                    idx_sync <= pay[0];
                    idx_pol  <= pay[1];
                end
                default: ;
            endcase
        end
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (sel_ctl) begin
            rdata = {2'b00, dir, err, 2'b00, ct, bt};
        end else begin
            for (int i = 0; i < NBYTES; i++)
                if (ptr_q == PTR_W'(i)) rdata = latch_q[8*i +: 8];
        end
    end

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_LAST);                                             // R3
    AST_PTR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && pay[0]) |=> (ptr_q == '0));                         // R3
    AST_FOREIGN_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && tgt[2]) |=> ($stable(cmode) && $stable(imode)
                                && $stable(ab_en) && $stable(idx_pol))); // R2

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enc_a,
    input  logic     enc_b,
    input  logic     enc_idx,
    input  in_mode_e imode,
    input  logic     ab_en,
    input  logic     idx_sync,
    input  logic     idx_pol,
    output logic     up_p,
    output logic     dn_p,
    output logic     noise_p,
    output logic     idx_ev
);
    logic   a_s, b_s, i_s, i_q;
    phase_e phase_q, phase_d;
    logic   a_chg, b_chg, w_x2, w_x4;
    logic   act, act_prev, sync_ok, gate, gate_prev;

    // Input sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_s <= 1'b0;
            b_s <= 1'b0;
            i_s <= 1'b0;
            i_q <= 1'b0;
        end else begin
            a_s <= enc_a;
            b_s <= enc_b;
            i_s <= enc_idx;
            i_q <= i_s;
        end
    end

    // Phase state register
    assign phase_d = phase_e'({a_s, b_s});
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_LL;
        else        phase_q <= phase_d;
    end

    assign a_chg = a_s ^ phase_q[1];
    assign b_chg = b_s ^ phase_q[0];
    assign w_x2  = (imode == IM_X2) || (imode == IM_X4);
    assign w_x4  = (imode == IM_X4);

    // Transition outputs
    always_comb begin
        up_p    = 1'b0;
        dn_p    = 1'b0;
        noise_p = 1'b0;
        if (ab_en) begin
            if (imode == IM_PLAIN) begin
                if (a_s && !phase_q[1]) begin
                    up_p = b_s;
                    dn_p = ~b_s;
                end
            end else if (a_chg && b_chg) begin
                noise_p = 1'b1;
            end else begin
                unique case (phase_q)
                    PH_LL: begin
                        up_p = a_chg;
                        dn_p = b_chg & w_x4;
                    end
                    PH_HL: begin
                        up_p = b_chg & w_x4;
                        dn_p = a_chg;
                    end
                    PH_HH: begin
                        up_p = a_chg & w_x2;
                        dn_p = b_chg & w_x4;
                    end
                    PH_LH: begin
                        up_p = b_chg & w_x4;
                        dn_p = a_chg & w_x2;
                    end
                endcase
            end
        end
    end

    // Index event
    assign act       = idx_pol ? i_s : ~i_s;
    assign act_prev  = idx_pol ? i_q : ~i_q;
    assign sync_ok   = idx_sync && (imode != IM_PLAIN);
    assign gate      = sync_ok ? (act & ~a_s & ~b_s) : act;
    assign gate_prev = sync_ok ? (act_prev & ~phase_q[1] & ~phase_q[0]) : act_prev;
    assign idx_ev    = gate & ~gate_prev;

    AST_PLAIN_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((imode == IM_PLAIN) && (up_p || dn_p)) |-> (a_s && !$past(a_s))); // R6
    AST_DOUBLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_en && (imode != IM_PLAIN) && (a_s != $past(a_s)) && (b_s != $past(b_s)))
        |-> (noise_p && !up_p && !dn_p));                                 // R8
    AST_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_p && dn_p));                                                 // R7

endmodule

// File: rtl/qenc_count.sv
module qenc_count
    import qenc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_p,
    input  logic             dn_p,
    input  logic             noise_p,
    input  logic             idx_ev,
    input  logic             idx_load_n,
    input  logic [CNT_W-1:0] preset,
    input  cnt_mode_e        cmode,
    input  logic             cmd_load,
    input  logic             cmd_clr_cnt,
    input  logic             cmd_clr_flags,
    input  logic             cmd_clr_err,
    output logic [CNT_W-1:0] cnt,
    output logic             bt,
    output logic             ct,
    output logic             err,
    output logic             dir
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic bt_q, ct_q, err_q, dir_q;
    logic bt_t, ct_t, load, step;
    run_e run_q, run_d;

    assign load = cmd_load | (idx_ev & ~idx_load_n);
    assign step = (up_p | dn_p) && (run_q == RUN_ACTIVE);

    // Next count
    always_comb begin
        cnt_d = cnt_q;
        bt_t  = 1'b0;
        ct_t  = 1'b0;
        if (load) begin
            cnt_d = preset;
        end else if (cmd_clr_cnt) begin
            cnt_d = '0;
        end else if (step && up_p) begin
            unique case (cmode)
                CM_RANGE: begin
                    if (cnt_q != preset) begin
                        cnt_d = cnt_q + CNT_ONE;
                        ct_t  = (cnt_q == CNT_MAX);
                    end
                end
                CM_MODULO: begin
                    if ((cnt_q == preset) || (cnt_q == CNT_MAX)) begin
                        cnt_d = '0;
                        ct_t  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
                default: begin
                    cnt_d = cnt_q + CNT_ONE;
                    ct_t  = (cnt_q == CNT_MAX);
                end
            endcase
        end else if (step && dn_p) begin
            unique case (cmode)
                CM_RANGE: begin
                    if (cnt_q != '0) cnt_d = cnt_q - CNT_ONE;
                end
                CM_MODULO: begin
                    if (cnt_q == '0) begin
                        cnt_d = preset;
                        bt_t  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
                default: begin
                    cnt_d = cnt_q - CNT_ONE;
                    bt_t  = (cnt_q == '0);
                end
            endcase
        end
    end

    // Run state machine: next state
    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_ACTIVE:
                if (!load && !cmd_clr_cnt && (cmode == CM_ONESHOT) && (bt_t || ct_t))
                    run_d = RUN_HALTED;
            RUN_HALTED:
                if (load || cmd_clr_cnt)
                    run_d = RUN_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= RUN_ACTIVE;
        else        run_q <= run_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bt_q  <= 1'b0;
            ct_q  <= 1'b0;
            err_q <= 1'b0;
            dir_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            bt_q  <= cmd_clr_flags ? 1'b0 : (bt_q ^ bt_t);
            ct_q  <= cmd_clr_flags ? 1'b0 : (ct_q ^ ct_t);
            err_q <= cmd_clr_err ? 1'b0 : (err_q | noise_p);
            if (up_p || dn_p) dir_q <= up_p;
        end
    end

    assign cnt = cnt_q;
    assign bt  = bt_q;
    assign ct  = ct_q;
    assign err = err_q;
    assign dir = dir_q;

    AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmode == CM_RANGE) && up_p && (run_q == RUN_ACTIVE) && !load && !cmd_clr_cnt
         && (cnt_q == preset)) |=> $stable(cnt_q));                      // R10
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_q == RUN_HALTED) && !load && !cmd_clr_cnt) |=> $stable(cnt_q)); // R11
    AST_MODN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmode == CM_MODULO) && dn_p && (run_q == RUN_ACTIVE) && !load && !cmd_clr_cnt
         && (cnt_q == '0)) |=> (cnt_q == $past(preset)));                // R12
    AST_BORROW_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmode == CM_NORMAL) && dn_p && (run_q == RUN_ACTIVE) && !load && !cmd_clr_cnt
         && !cmd_clr_flags && (cnt_q == '0)) |=> (bt_q != $past(bt_q)));  // R9

endmodule

// File: rtl/qenc_channel.sv
module qenc_channel
    import qenc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_stb,
    input  logic       host_wr,
    input  logic       host_ctl,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic       enc_idx
);
    logic [CNT_W-1:0] cnt, preset;
    logic bt, ct, err, dir;
    cnt_mode_e cmode;
    in_mode_e  imode;
    logic ab_en, idx_load_n, idx_sync, idx_pol;
    logic cmd_load, cmd_clr_cnt, cmd_clr_flags, cmd_clr_err;
    logic up_p, dn_p, noise_p, idx_ev;

    qenc_host #(.CNT_W(CNT_W)) u_host (
        .clk(clk), .rst_n(rst_n), .stb(host_stb), .wr(host_wr), .sel_ctl(host_ctl),
        .wdata(host_wdata), .rdata(host_rdata), .cnt(cnt), .bt(bt), .ct(ct),
        .err(err), .dir(dir), .preset(preset), .cmode(cmode), .imode(imode),
        .ab_en(ab_en), .idx_load_n(idx_load_n), .idx_sync(idx_sync), .idx_pol(idx_pol),
        .cmd_load(cmd_load), .cmd_clr_cnt(cmd_clr_cnt), .cmd_clr_flags(cmd_clr_flags),
        .cmd_clr_err(cmd_clr_err)
    );

    qenc_decode u_dec (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .imode(imode), .ab_en(ab_en), .idx_sync(idx_sync), .idx_pol(idx_pol),
        .up_p(up_p), .dn_p(dn_p), .noise_p(noise_p), .idx_ev(idx_ev)
    );

    qenc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .up_p(up_p), .dn_p(dn_p), .noise_p(noise_p),
        .idx_ev(idx_ev), .idx_load_n(idx_load_n), .preset(preset), .cmode(cmode),
        .cmd_load(cmd_load), .cmd_clr_cnt(cmd_clr_cnt), .cmd_clr_flags(cmd_clr_flags),
        .cmd_clr_err(cmd_clr_err), .cnt(cnt), .bt(bt), .ct(ct), .err(err), .dir(dir)
    );

endmodule

// File: tb/qenc_channel_tb.sv
`timescale 1ns/1ps
module qenc_channel_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0, wr = 1'b0, sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic a = 1'b0, b = 1'b0, idx = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic [23:0] e_cnt, e_pre;
    bit e_bt, e_ct, e_halt;
    int e_cm, e_im;
    int ph = 0;

    always #4 clk = ~clk;   // 125 MHz

    qenc_channel u_dut (
        .clk(clk), .rst_n(rst_n), .host_stb(stb), .host_wr(wr), .host_ctl(sel),
        .host_wdata(wdata), .host_rdata(rdata), .enc_a(a), .enc_b(b), .enc_idx(idx)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(bit ctl, logic [7:0] d);
        @(negedge clk);
        stb = 1'b1; wr = 1'b1; sel = ctl; wdata = d;
        @(negedge clk);
        stb = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(bit ctl, output logic [7:0] v);
        @(negedge clk);
        stb = 1'b1; wr = 1'b0; sel = ctl;
        #1 v = rdata;
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic read_count(output logic [23:0] v);
        logic [7:0] t;
        bus_write(1'b1, 8'h11);
        for (int i = 0; i < 3; i++) begin
            bus_read(1'b0, t);
            v[8*i +: 8] = t;
        end
    endtask

    task automatic set_preset(logic [23:0] p);
        bus_write(1'b1, 8'h01);
        for (int i = 0; i < 3; i++) bus_write(1'b0, p[8*i +: 8]);
        e_pre = p;
    endtask

    function automatic bit pa(int p); return (p == 1) || (p == 2); endfunction
    function automatic bit pb(int p); return p >= 2; endfunction

    task automatic enc_drive(int p);
        @(negedge clk);
        a = pa(p); b = pb(p);
        repeat (3) @(negedge clk);
    endtask

    // does a step from phase p in direction up count in input mode im (R7)
    function automatic bit counts(int im, int p, bit up);
        case (im)
            3: return 1'b1;
            2: return up ? (p % 2 == 0) : (p % 2 == 1);
            1: return up ? (p == 0) : (p == 1);
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_step(bit up);
        if (!counts(e_im, ph, up) || e_halt) return;
        if (up) begin
            if (e_cm == 1 && e_cnt == e_pre) begin end
            else if (e_cm == 3 && (e_cnt == e_pre || e_cnt == 24'hFFFFFF)) begin
                e_cnt = 0; e_ct = ~e_ct;
            end else begin
                if (e_cnt == 24'hFFFFFF) begin e_ct = ~e_ct; if (e_cm == 2) e_halt = 1; end
                e_cnt = e_cnt + 1;
            end
        end else begin
            if (e_cm == 1 && e_cnt == 0) begin end
            else if (e_cm == 3 && e_cnt == 0) begin e_cnt = e_pre; e_bt = ~e_bt; end
            else begin
                if (e_cnt == 0) begin e_bt = ~e_bt; if (e_cm == 2) e_halt = 1; end
                e_cnt = e_cnt - 1;
            end
        end
    endtask

    task automatic enc_step(bit up);
        model_step(up);
        ph = up ? (ph + 1) % 4 : (ph + 3) % 4;
        enc_drive(ph);
    endtask

    task automatic walk(string req, int n, int every);
        logic [23:0] v;
        logic [7:0] s;
        for (int i = 0; i < n; i++) begin
            enc_step(1'($urandom % 2));
            if ((i + 1) % every == 0) begin
                read_count(v);
                chk(req, {8'h0, v}, {8'h0, e_cnt});
            end
        end
        bus_read(1'b1, s);
        chk(req, {30'h0, s[1:0]}, {30'h0, e_ct, e_bt});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] v;
        logic [7:0] s;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(1'b1, s);
        chk("R1 status", {24'h0, s}, 32'h0);
        for (int i = 0; i < 3; i++) begin
            bus_read(1'b0, s);
            chk("R1 latch byte", {24'h0, s}, 32'h0);
        end
        read_count(v);
        chk("R1 count", {8'h0, v}, 32'h0);

        // R3/R4 preset through pointer, load, latch
        set_preset(24'h123456);
        bus_write(1'b1, 8'h08);
        bus_write(1'b1, 8'h11);
        for (int i = 0; i < 4; i++) begin
            bus_read(1'b0, s);
            v = 24'h123456;
            chk("R3 byte order/wrap", {24'h0, s}, {24'h0, v[8*(i%3) +: 8]});
        end
        bus_write(1'b1, 8'h01);
        bus_read(1'b0, s);
        bus_write(1'b1, 8'h01);
        bus_read(1'b0, s);
        chk("R3 pointer reset", {24'h0, s}, 32'h56);

        set_preset(24'h000010);
        bus_write(1'b1, 8'h18);
        bus_write(1'b1, 8'h01);
        for (int i = 0; i < 3; i++) begin
            bus_read(1'b0, s);
            v[8*i +: 8] = s;
        end
        chk("R4 latch takes old count", {8'h0, v}, 32'h123456);
        read_count(v);
        chk("R4 preset load", {8'h0, v}, 32'h10);
        bus_write(1'b1, 8'h02);
        read_count(v);
        chk("R4 counter clear", {8'h0, v}, 32'h0);
        bus_write(1'b1, 8'h0A);
        read_count(v);
        chk("R4 load beats clear", {8'h0, v}, 32'h10);

        // R6 non-quadrature
        bus_write(1'b1, 8'h20);
        bus_write(1'b1, 8'h43);
        @(negedge clk); b = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); a = 1'b1; repeat (2) @(negedge clk); a = 1'b0; repeat (2) @(negedge clk);
        end
        read_count(v);
        chk("R6 up with B high", {8'h0, v}, 32'h13);
        @(negedge clk); b = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); a = 1'b1; repeat (2) @(negedge clk); a = 1'b0; repeat (2) @(negedge clk);
        end
        read_count(v);
        chk("R6 down with B low", {8'h0, v}, 32'h11);
        bus_read(1'b1, s);
        chk("R5 direction down", {31'h0, s[5]}, 32'h0);
        bus_write(1'b1, 8'h42);
        @(negedge clk); b = 1'b1; a = 1'b1; repeat (3) @(negedge clk); a = 1'b0; repeat (3) @(negedge clk);
        read_count(v);
        chk("R6 disabled inputs", {8'h0, v}, 32'h11);

        // R2 foreign target codes
        bus_write(1'b1, 8'h9F);
        bus_write(1'b1, 8'hFF);
        @(negedge clk); a = 1'b1; repeat (3) @(negedge clk); a = 1'b0; repeat (3) @(negedge clk);
        read_count(v);
        chk("R2 unknown target ignored", {8'h0, v}, 32'h11);
        @(negedge clk); b = 1'b0; repeat (3) @(negedge clk);
        ph = 0;

        // R9/R5 normal x4 wrap
        bus_write(1'b1, 8'h38);
        bus_write(1'b1, 8'h43);
        bus_write(1'b1, 8'h02);
        bus_write(1'b1, 8'h04);
        e_cnt = 0; e_bt = 0; e_ct = 0; e_halt = 0; e_cm = 0; e_im = 3;
        enc_step(1'b0);
        read_count(v);
        chk("R9 underflow wrap", {8'h0, v}, 32'hFFFFFF);
        bus_read(1'b1, s);
        chk("R5 status after borrow", {24'h0, s}, 32'h01);
        enc_step(1'b1);
        read_count(v);
        chk("R9 overflow wrap", {8'h0, v}, 32'h0);
        bus_read(1'b1, s);
        chk("R5 status after carry", {24'h0, s}, 32'h23);
        chk("R9 bit24 is bt xor ct", {31'h0, s[0] ^ s[1]}, 32'h0);
        bus_write(1'b1, 8'h04);
        bus_read(1'b1, s);
        chk("R4 flag clear", {24'h0, s}, 32'h20);
        e_bt = 0; e_ct = 0;

        // R7 random walks
        walk("R7 x4 walk", 150, 10);
        bus_write(1'b1, 8'h30); e_im = 2;
        walk("R7 x2 walk", 60, 15);
        bus_write(1'b1, 8'h28); e_im = 1;
        walk("R7 x1 walk", 60, 15);
        bus_write(1'b1, 8'h38); e_im = 3;

        // R8 noise
        read_count(v);
        ph = (ph + 2) % 4;
        enc_drive(ph);
        read_count(e_cnt);
        chk("R8 no count on double change", {8'h0, e_cnt}, {8'h0, v});
        bus_read(1'b1, s);
        chk("R8 noise flag set", {31'h0, s[4]}, 32'h1);
        bus_write(1'b1, 8'h06);
        bus_read(1'b1, s);
        chk("R4 noise clear", {31'h0, s[4]}, 32'h0);

        // R10 range limit
        bus_write(1'b1, 8'h3A); e_cm = 1;
        set_preset(24'h3);
        bus_write(1'b1, 8'h02);
        for (int i = 0; i < 5; i++) enc_step(1'b1);
        read_count(v);
        chk("R10 upper hold", {8'h0, v}, 32'h3);
        for (int i = 0; i < 5; i++) enc_step(1'b0);
        read_count(v);
        chk("R10 lower hold", {8'h0, v}, 32'h0);

        // R12 modulo-n
        bus_write(1'b1, 8'h3E);
        set_preset(24'h4);
        bus_write(1'b1, 8'h02);
        bus_write(1'b1, 8'h04);
        enc_step(1'b0);
        read_count(v);
        chk("R12 reload on underflow", {8'h0, v}, 32'h4);
        bus_read(1'b1, s);
        chk("R12 borrow toggled", {30'h0, s[1:0]}, 32'h1);
        e_cm = 3; e_cnt = 24'h4; e_bt = 1; e_ct = 0; e_halt = 0;
        walk("R12 modulo walk", 40, 5);

        // R11 non-recycle
        bus_write(1'b1, 8'h3C);
        bus_write(1'b1, 8'h02);
        enc_step(1'b0);
        read_count(v);
        chk("R11 wrap", {8'h0, v}, 32'hFFFFFF);
        enc_step(1'b0);
        enc_step(1'b1);
        read_count(v);
        chk("R11 frozen", {8'h0, v}, 32'hFFFFFF);
        bus_write(1'b1, 8'h08);
        enc_step(1'b1);
        read_count(v);
        chk("R11 resumes after load", {8'h0, v}, 32'h5);

        // R13 index
        bus_write(1'b1, 8'h38);
        bus_write(1'b1, 8'h41);
        bus_write(1'b1, 8'h62);
        set_preset(24'h50);
        bus_write(1'b1, 8'h02);
        @(negedge clk); idx = 1'b1; repeat (3) @(negedge clk);
        read_count(v);
        chk("R13 rising index loads", {8'h0, v}, 32'h50);
        @(negedge clk); idx = 1'b0; repeat (3) @(negedge clk);
        bus_write(1'b1, 8'h43);
        bus_write(1'b1, 8'h02);
        @(negedge clk); idx = 1'b1; repeat (3) @(negedge clk);
        read_count(v);
        chk("R13 load disabled", {8'h0, v}, 32'h0);
        bus_write(1'b1, 8'h41);
        bus_write(1'b1, 8'h60);
        @(negedge clk); idx = 1'b0; repeat (3) @(negedge clk);
        read_count(v);
        chk("R13 falling index loads", {8'h0, v}, 32'h50);
        // synchronous: park at phase HL, raise index, then move to LL
        bus_write(1'b1, 8'h63);
        while (ph != 1) begin ph = (ph + 1) % 4; enc_drive(ph); end
        bus_write(1'b1, 8'h02);
        @(negedge clk); idx = 1'b1; repeat (3) @(negedge clk);
        read_count(v);
        chk("R13 sync gated by phase", {8'h0, v}, 32'h0);
        ph = 0; enc_drive(ph);
        read_count(v);
        chk("R13 sync load beats step", {8'h0, v}, 32'h50);
        // sync bit ignored in non-quadrature mode
        @(negedge clk); idx = 1'b0; repeat (3) @(negedge clk);
        bus_write(1'b1, 8'h20);
        bus_write(1'b1, 8'h40);
        @(negedge clk); a = 1'b1; repeat (3) @(negedge clk);
        bus_write(1'b1, 8'h02);
        @(negedge clk); idx = 1'b1; repeat (3) @(negedge clk);
        read_count(v);
        chk("R13 sync ignored without quadrature", {8'h0, v}, 32'h50);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule